// File: doc/BRIEF.md
# Planar Display Memory Write Datapath

This block sits between a CPU data path and a display memory organised as four parallel bit planes that share one address. It turns one CPU byte into four plane bytes and four plane write strobes. Four 8-bit read latches capture the plane bytes every time the memory is read. A later write can then merge new data with those stored pixels, or copy them unchanged to another address.

A 2-bit write mode picks how each plane byte is formed. Mode 0 rotates the CPU byte and can force whole planes to a fixed colour bit. Mode 1 copies the latches. Mode 2 spreads one CPU bit over each plane. Mode 3 paints the fixed colour through a pattern taken from the rotated CPU byte. A logic function and a per-pixel bit mask decide how the computed bits combine with the latched bits. The configuration inputs are sampled on the same cycle as the write strobe. The plane data and strobes appear one clock later.

Top module: `planar_wr_datapath`

## Requirements
- R1: After reset, wr_data_o and wr_stb_o are zero and all four latches hold zero, so a mode 1 write issued before any read produces all-zero plane data.
- R2: A cycle with rd_i high loads bits [8p+7:8p] of rd_data_i into the latch of plane p, for every plane p.
- R3: rot_i (0 to 7) rotates the CPU byte right: bit b of the rotated byte is CPU bit (b+rot_i) mod 8. The rotated byte is used in modes 0 and 3.
- R4: func_i combines the source bits with the latch in modes 0 and 2. The encodings are 0 = source unchanged, 1 = source AND latch, 2 = source OR latch, 3 = source XOR latch. In mode 3 this function is bypassed.
- R5: In mode 0 (wr_mode_i = 0), each plane p whose sr_en_i[p] is 1 uses eight copies of set_reset_i[p] as its source in place of the rotated CPU byte.
- R6: In mode 1, each plane's write data equals that plane's latch byte, regardless of the CPU byte, the function and the mask.
- R7: In mode 2, the source of plane p is eight copies of CPU bit p.
- R8: In mode 3, each pixel bit b of plane p takes set_reset_i[p] where (rotated CPU byte AND bit_mask_i) bit b is 1, and takes the latch bit otherwise.
- R9: In modes 0 and 2, a bit_mask_i bit of 1 passes the computed bit, and a bit of 0 keeps the latched bit at that position.
- R10: One cycle after wr_i is high, wr_stb_o equals the plane_en_i sampled with that write, and wr_data_o holds that write's result. After a cycle with wr_i low, wr_stb_o is zero and wr_data_o is unchanged.
- R11: When rd_i and wr_i are high in the same cycle, the write uses the latch contents from before that read's load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Memory read this cycle; loads the latches |
| rd_data_i | input | 32 | Plane bytes read; plane p at bits [8p+7:8p] |
| wr_i | input | 1 | CPU write this cycle |
| cpu_data_i | input | 8 | CPU write byte |
| wr_mode_i | input | 2 | Write mode 0 to 3 |
| set_reset_i | input | 4 | Fixed colour bit per plane |
| sr_en_i | input | 4 | Per-plane substitution enable for mode 0 |
| rot_i | input | 3 | Right-rotate count |
| func_i | input | 2 | Logic function: pass, AND, OR, XOR |
| bit_mask_i | input | 8 | Per-pixel write enable against the latch |
| plane_en_i | input | 4 | Per-plane write enable |
| wr_data_o | output | 32 | Registered plane write data, plane p at [8p+7:8p] |
| wr_stb_o | output | 4 | Registered per-plane write strobe |

## Verification
The assertions assume that rd_i, wr_i and every configuration input are held low or zero while reset is asserted. This keeps the first $past value after reset meaningful. The bench drives all inputs at the falling edge and keeps them low during reset. It samples outputs at the following falling edge, so each write's configuration is stable around the capturing edge. Reads and writes are issued alone, and also together to exercise the same-cycle ordering.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {
    WM_MERGE = 2'd0,
    WM_COPY  = 2'd1,
    WM_SPLAT = 2'd2,
    WM_FILL  = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    LF_PASS = 2'd0,
    LF_AND  = 2'd1,
    LF_OR   = 2'd2,
    LF_XOR  = 2'd3
  } lfunc_e;
endpackage

// File: rtl/pwd_rotator.sv
module pwd_rotator #(
  parameter int DW = 8,
  localparam int RW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  logic [RW-1:0] amt_i,
  output logic [DW-1:0] data_o
);
  logic [2*DW-1:0] dbl;
  always_comb begin
    dbl    = {data_i, data_i} >> amt_i;
    data_o = dbl[DW-1:0];
  end
endmodule

// File: rtl/pwd_latch_bank.sv
module pwd_latch_bank #(
  parameter int PLANES = 4,
  parameter int DW = 8,
  localparam int BW = PLANES * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] q_o
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[p*DW +: DW] <= '0;
      else if (load_i) q_o[p*DW +: DW] <= data_i[p*DW +: DW];
    end
  end
endmodule

// File: rtl/pwd_plane_lane.sv
module pwd_plane_lane
  import pwd_pkg::*;
#(
  parameter int DW = 8
) (
  input  wmode_e        mode_i,
  input  lfunc_e        func_i,
  input  logic [DW-1:0] rot_data_i,
  input  logic          cpu_bit_i,
  input  logic          sr_i,
  input  logic          sr_en_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] latch_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] src, alu, merged, fill_sel;

  always_comb begin
    unique case (mode_i)
      WM_SPLAT: src = {DW{cpu_bit_i}};
      default:  src = sr_en_i ? {DW{sr_i}} : rot_data_i;
    endcase
  end

  always_comb begin
    unique case (func_i)
      LF_AND:  alu = src & latch_i;
      LF_OR:   alu = src | latch_i;
      LF_XOR:  alu = src ^ latch_i;
      default: alu = src;
    endcase
  end

  always_comb begin
    merged   = (alu & mask_i) | (latch_i & ~mask_i);
    fill_sel = rot_data_i & mask_i;
    unique case (mode_i)
      WM_COPY: res_o = latch_i;
      WM_FILL: res_o = (fill_sel & {DW{sr_i}}) | (latch_i & ~fill_sel);
      default: res_o = merged;
    endcase
  end
endmodule

// File: rtl/planar_wr_datapath.sv
module planar_wr_datapath
  import pwd_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int DW = 8,
  localparam int RW = $clog2(DW),
  localparam int BW = PLANES * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [BW-1:0]     rd_data_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     cpu_data_i,
  input  logic [1:0]        wr_mode_i,
  input  logic [PLANES-1:0] set_reset_i,
  input  logic [PLANES-1:0] sr_en_i,
  input  logic [RW-1:0]     rot_i,
  input  logic [1:0]        func_i,
  input  logic [DW-1:0]     bit_mask_i,
  input  logic [PLANES-1:0] plane_en_i,
  output logic [BW-1:0]     wr_data_o,
  output logic [PLANES-1:0] wr_stb_o
);
  logic [BW-1:0] latch_q;
  logic [BW-1:0] res;
  logic [DW-1:0] rot_data;
  wmode_e        mode;
  lfunc_e        func;

  assign mode = wmode_e'(wr_mode_i);
  assign func = lfunc_e'(func_i);

  pwd_latch_bank #(.PLANES(PLANES), .DW(DW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rd_i),
    .data_i (rd_data_i),
    .q_o    (latch_q)
  );

  pwd_rotator #(.DW(DW)) u_rot (
    .data_i (cpu_data_i),
    .amt_i  (rot_i),
    .data_o (rot_data)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    pwd_plane_lane #(.DW(DW)) u_lane (
      .mode_i     (mode),
      .func_i     (func),
      .rot_data_i (rot_data),
      .cpu_bit_i  (cpu_data_i[p % DW]),
      .sr_i       (set_reset_i[p]),
      .sr_en_i    (sr_en_i[p]),
      .mask_i     (bit_mask_i),
      .latch_i    (latch_q[p*DW +: DW]),
      .res_o      (res[p*DW +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_data_o <= '0;
      wr_stb_o  <= '0;
    end else begin
      wr_stb_o <= wr_i ? plane_en_i : '0;
      if (wr_i) wr_data_o <= res;
    end
  end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int PLANES = 4,
  parameter int DW = 8,
  localparam int RW = $clog2(DW),
  localparam int BW = PLANES * DW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [BW-1:0]     rd_data_i,
  input logic              wr_i,
  input logic [DW-1:0]     cpu_data_i,
  input logic [1:0]        wr_mode_i,
  input logic [DW-1:0]     bit_mask_i,
  input logic [1:0]        func_i,
  input logic [PLANES-1:0] plane_en_i,
  input logic [BW-1:0]     latch_q,
  input logic [BW-1:0]     wr_data_o,
  input logic [PLANES-1:0] wr_stb_o
);
  p_latch_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> latch_q == $past(rd_data_i));

  p_copy_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_mode_i == 2'd1) |=> wr_data_o == $past(latch_q));

  p_splat_plane0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_mode_i == 2'd2 && func_i == 2'd0 && bit_mask_i == {DW{1'b1}})
      |=> wr_data_o[DW-1:0] == {DW{$past(cpu_data_i[0])}});

  p_zero_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bit_mask_i == '0) |=> wr_data_o == $past(latch_q));

  p_stb_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> wr_stb_o == $past(plane_en_i));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (wr_stb_o == '0) && $stable(wr_data_o));
endmodule

bind planar_wr_datapath pwd_checker #(.PLANES(PLANES), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .rd_data_i  (rd_data_i),
  .wr_i       (wr_i),
  .cpu_data_i (cpu_data_i),
  .wr_mode_i  (wr_mode_i),
  .bit_mask_i (bit_mask_i),
  .func_i     (func_i),
  .plane_en_i (plane_en_i),
  .latch_q    (latch_q),
  .wr_data_o  (wr_data_o),
  .wr_stb_o   (wr_stb_o)
);

// File: tb/tb_planar_wr_datapath.sv
module tb_planar_wr_datapath;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic [7:0]  cpu_data_i = '0, bit_mask_i = '0;
  logic [1:0]  wr_mode_i = '0, func_i = '0;
  logic [3:0]  set_reset_i = '0, sr_en_i = '0, plane_en_i = '0;
  logic [2:0]  rot_i = '0;
  logic [31:0] wr_data_o;
  logic [3:0]  wr_stb_o;

  planar_wr_datapath dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .rd_data_i(rd_data_i),
    .wr_i(wr_i), .cpu_data_i(cpu_data_i), .wr_mode_i(wr_mode_i),
    .set_reset_i(set_reset_i), .sr_en_i(sr_en_i), .rot_i(rot_i),
    .func_i(func_i), .bit_mask_i(bit_mask_i), .plane_en_i(plane_en_i),
    .wr_data_o(wr_data_o), .wr_stb_o(wr_stb_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int lat [4];
  int exp_d [4];
  int exp_stb = 0;

  function automatic int calc(int p);
    int res, c, l, s, m, src, op, v;
    res = 0;
    for (int b = 0; b < 8; b++) begin
      c = (int'(cpu_data_i) >> ((b + int'(rot_i)) % 8)) & 1;
      l = (lat[p] >> b) & 1;
      s = (int'(set_reset_i) >> p) & 1;
      m = (int'(bit_mask_i) >> b) & 1;
      if (wr_mode_i == 2'd2) src = (int'(cpu_data_i) >> p) & 1;
      else src = ((int'(sr_en_i) >> p) & 1) != 0 ? s : c;
      case (func_i)
        2'd1: op = src & l;
        2'd2: op = src | l;
        2'd3: op = src ^ l;
        default: op = src;
      endcase
      case (wr_mode_i)
        2'd1: v = l;
        2'd3: v = (c & m) != 0 ? s : l;
        default: v = m != 0 ? op : l;
      endcase
      res = res | (v << b);
    end
    return res;
  endfunction

  task automatic compare(input string tag);
    int act, ex;
    for (int p = 0; p < 4; p++) begin
      act = int'(wr_data_o[p*8 +: 8]);
      total++;
      if (act != exp_d[p]) begin
        bad++;
        $display("FAIL %s plane %0d data actual=%02h expected=%02h", tag, p, act, exp_d[p]);
      end
    end
    total++;
    if (int'(wr_stb_o) != exp_stb) begin
      bad++;
      $display("FAIL %s strobe actual=%01h expected=%01h", tag, wr_stb_o, exp_stb);
    end
  endtask

  // Called just after a falling edge; config already set.
  task automatic step(input bit rd, input logic [31:0] rdata, input bit wr, input string tag);
    rd_i = rd; rd_data_i = rdata; wr_i = wr;
    if (wr) begin
      for (int p = 0; p < 4; p++) exp_d[p] = calc(p);
      exp_stb = int'(plane_en_i);
    end else exp_stb = 0;
    if (rd) for (int p = 0; p < 4; p++) lat[p] = int'(rdata[p*8 +: 8]);
    @(negedge clk);
    compare(tag);
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] md, input logic [1:0] fn, input logic [2:0] rt,
                     input logic [7:0] mk, input logic [3:0] sr, input logic [3:0] se,
                     input logic [3:0] pe, input logic [7:0] cpu);
    wr_mode_i = md; func_i = fn; rot_i = rt; bit_mask_i = mk;
    set_reset_i = sr; sr_en_i = se; plane_en_i = pe; cpu_data_i = cpu;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin lat[p] = 0; exp_d[p] = 0; end
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: latches zero after reset
    cfg(2'd1, 2'd0, 3'd0, 8'hff, 4'h0, 4'h0, 4'hf, 8'h5a);
    step(0, 0, 1, "R1 copy after reset");
    // R2 / R6: load then copy, mask and cpu ignored
    step(1, 32'h44332211, 0, "R2 load");
    cfg(2'd1, 2'd3, 3'd5, 8'h00, 4'ha, 4'hf, 4'hf, 8'hc3);
    step(0, 0, 1, "R6 copy latch");
    step(0, 0, 0, "R10 idle hold");
    // R3: rotate sweep
    for (int r = 0; r < 8; r++) begin
      cfg(2'd0, 2'd0, 3'(r), 8'hff, 4'h0, 4'h0, 4'hf, 8'h96);
      step(0, 0, 1, "R3 rotate");
    end
    // R4: logic functions against latch
    step(1, 32'hf00fcc33, 0, "R2 load");
    for (int f = 0; f < 4; f++) begin
      cfg(2'd0, 2'(f), 3'd1, 8'hff, 4'h0, 4'h0, 4'hf, 8'h3c);
      step(0, 0, 1, "R4 function");
    end
    // R5: set/reset substitution
    cfg(2'd0, 2'd0, 3'd2, 8'hff, 4'h3, 4'h5, 4'hf, 8'h81);
    step(0, 0, 1, "R5 set/reset");
    cfg(2'd0, 2'd3, 3'd0, 8'hff, 4'hc, 4'hf, 4'hf, 8'h00);
    step(0, 0, 1, "R5 set/reset xor");
    // R7: replication
    cfg(2'd2, 2'd0, 3'd6, 8'hff, 4'h0, 4'hf, 4'hf, 8'h0a);
    step(0, 0, 1, "R7 splat");
    cfg(2'd2, 2'd2, 3'd0, 8'h3c, 4'h0, 4'h0, 4'hf, 8'h05);
    step(0, 0, 1, "R7 splat or masked");
    // R8: fill
    cfg(2'd3, 2'd1, 3'd3, 8'hf0, 4'h9, 4'h0, 4'hf, 8'ha5);
    step(0, 0, 1, "R8 fill");
    cfg(2'd3, 2'd3, 3'd0, 8'hff, 4'h6, 4'h0, 4'hf, 8'h0f);
    step(0, 0, 1, "R8 fill xor bypass");
    // R9: masks
    cfg(2'd0, 2'd0, 3'd0, 8'h0f, 4'h0, 4'h0, 4'hf, 8'hff);
    step(0, 0, 1, "R9 mask 0f");
    cfg(2'd0, 2'd2, 3'd4, 8'ha5, 4'h0, 4'h0, 4'hf, 8'h12);
    step(0, 0, 1, "R9 mask a5");
    cfg(2'd2, 2'd0, 3'd0, 8'h00, 4'h0, 4'h0, 4'hf, 8'h0f);
    step(0, 0, 1, "R9 mask zero");
    // R10: plane enables and idle
    cfg(2'd0, 2'd0, 3'd0, 8'hff, 4'h0, 4'h0, 4'h5, 8'h77);
    step(0, 0, 1, "R10 strobe 5");
    step(0, 0, 0, "R10 idle");
    cfg(2'd0, 2'd0, 3'd0, 8'hff, 4'h0, 4'h0, 4'h0, 8'h11);
    step(0, 0, 1, "R10 strobe none");
    step(1, 32'h01020304, 0, "R10 read only");
    // R11: same-cycle read and write
    cfg(2'd1, 2'd0, 3'd0, 8'hff, 4'h0, 4'h0, 4'hf, 8'h00);
    step(1, 32'hdeadbeef, 1, "R11 read+write");
    step(0, 0, 1, "R11 copy new latch");
    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      cfg(2'($urandom), 2'($urandom), 3'($urandom), 8'($urandom), 4'($urandom),
          4'($urandom), 4'($urandom), 8'($urandom));
      step(1'($urandom), $urandom, 1'($urandom), "R4 mixed");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule